// File: doc/BRIEF.md
# Memory-Mapped Character Output Port

This block is the display side of a small processor's memory-mapped I/O. It sits on a 16-bit load/store bus and presents two words to software. The first is a status word. It holds a ready flag, which software can read, and an interrupt-enable bit, which software can write. The second is a data word. A character stored into the data word is handed to a downstream character sink, which is typically the display electronics.

While the sink is working on a character, the port reports busy. Any further character stores during that time are dropped. When the sink signals that it has finished, the port reports ready again. If software has set the interrupt-enable bit, the port then raises its interrupt request. Software can therefore either poll the ready flag or wait for the interrupt.

Top module: `dout_port`

## Requirements
- R1: After a synchronous reset the ready flag is 1, the interrupt-enable bit is 0, `irq` is 0 and `out_vld` is 0.
- R2: A read with `bus_addr` = 0xFE04 returns the ready flag in bit 15 and the interrupt-enable bit in bit 14. All other bits read as 0.
- R3: A write to 0xFE06 while ready is 1 is accepted. In the next cycle `out_vld` is 1 for exactly one cycle, `out_char` equals bits [7:0] of the written word, and the ready flag reads 0.
- R4: A write to 0xFE06 while ready is 0 is ignored. It produces no `out_vld` pulse and leaves the stored character unchanged.
- R5: While ready is 0, a cycle with `sink_done` = 1 sets ready to 1 in the following cycle. While ready is 1, `sink_done` has no effect.
- R6: A write to 0xFE04 loads the interrupt-enable bit from bit 14 of the written word. Bit 15 of that write does not change the ready flag.
- R7: `irq` is 1 exactly when the ready flag and the interrupt-enable bit are both 1.
- R8: A read of 0xFE06 returns the last accepted character in bits [7:0], with bits [15:8] as 0.
- R9: A read of any other address returns 0, and a write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not selected |
| out_vld | output | 1 | One-cycle pulse handing a character to the sink |
| out_char | output | 8 | Character code for the sink |
| sink_done | input | 1 | Sink has finished the current character |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with its default parameters. These place the status word at 0xFE04 and the data word at 0xFE06, with ready at bit 15 and interrupt-enable at bit 14. The two decoded addresses differ only in bit 1, so probes at 0xFE05 and 0xFE07 test that the address decode matches the full word exactly. Keeping ready and interrupt-enable in neighbouring bits lets a single status write with bit 15 set show that the ready flag cannot be written. The bench also drives a data write in the same cycle as `sink_done` to show that the write is dropped while the port still becomes ready.

// File: rtl/dout_pkg.sv
package dout_pkg;

  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_DATA = 2'd2
  } dout_tgt_e;

  // Build the status word from the two flag bits at their positions.
  function automatic logic [WORD_W-1:0] status_word(input logic rdy, input logic ie,
                                                    input int rdy_pos, input int ie_pos);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) begin
      w[i] = (i == rdy_pos) ? rdy : ((i == ie_pos) ? ie : 1'b0);
    end
    return w;
  endfunction

  // Zero-extend a character to a bus word.
  function automatic logic [WORD_W-1:0] char_word(input logic [CHAR_W-1:0] c);
    return {{(WORD_W-CHAR_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/dout_decode.sv
module dout_decode
  import dout_pkg::*;
#(
  parameter logic [WORD_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [WORD_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic [WORD_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output dout_tgt_e         tgt,
  output logic              wr_stat,
  output logic              wr_data,
  output logic              rd_stat,
  output logic              rd_data
);

  always_comb begin
    if (addr == STAT_ADDR)      tgt = TGT_STAT;
    else if (addr == DATA_ADDR) tgt = TGT_DATA;
    else                        tgt = TGT_NONE;
  end

  assign wr_stat = wr && (tgt == TGT_STAT);
  assign wr_data = wr && (tgt == TGT_DATA);
  assign rd_stat = rd && (tgt == TGT_STAT);
  assign rd_data = rd && (tgt == TGT_DATA);

endmodule

// File: rtl/dout_status.sv
module dout_status (
  input  logic clk,
  input  logic rst,
  input  logic stat_take,
  input  logic ie_in,
  input  logic data_take,
  input  logic sink_done,
  output logic rdy_q,
  output logic ie_q,
  output logic done_take
);

  // A done only counts while a character is outstanding.
  assign done_take = sink_done && !rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b1;
      ie_q  <= 1'b0;
    end else begin
      if (data_take)      rdy_q <= 1'b0;
      else if (done_take) rdy_q <= 1'b1;
      if (stat_take)      ie_q  <= ie_in;
    end
  end

endmodule

// File: rtl/dout_handoff.sv
module dout_handoff
  import dout_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              data_take,
  input  logic [CHAR_W-1:0] char_in,
  output logic              vld_q,
  output logic [CHAR_W-1:0] char_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      char_q <= '0;
    end else begin
      vld_q <= data_take;
      if (data_take) char_q <= char_in;
    end
  end

endmodule

// File: rtl/dout_port.sv
module dout_port
  import dout_pkg::*;
#(
  parameter logic [WORD_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [WORD_W-1:0] DATA_ADDR = 16'hFE06,
  parameter int                RDY_BIT   = 15,
  parameter int                IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              out_vld,
  output logic [CHAR_W-1:0] out_char,
  input  logic              sink_done,
  output logic              irq
);

  dout_tgt_e tgt;
  logic wr_stat, wr_data, rd_stat, rd_data;
  logic rdy_q, ie_q;
  // Named internal events, also watched by the checker.
  logic data_take, stat_take, done_take;

  dout_decode #(.STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .tgt(tgt),
    .wr_stat(wr_stat), .wr_data(wr_data), .rd_stat(rd_stat), .rd_data(rd_data)
  );

  assign data_take = wr_data && rdy_q;
  assign stat_take = wr_stat;

  dout_status u_stat (
    .clk(clk), .rst(rst), .stat_take(stat_take), .ie_in(bus_wdata[IE_BIT]),
    .data_take(data_take), .sink_done(sink_done),
    .rdy_q(rdy_q), .ie_q(ie_q), .done_take(done_take)
  );

  dout_handoff u_hand (
    .clk(clk), .rst(rst), .data_take(data_take), .char_in(bus_wdata[CHAR_W-1:0]),
    .vld_q(out_vld), .char_q(out_char)
  );

  always_comb begin
    if (rd_stat)      bus_rdata = status_word(rdy_q, ie_q, RDY_BIT, IE_BIT);
    else if (rd_data) bus_rdata = char_word(out_char);
    else              bus_rdata = '0;
  end

  assign irq = rdy_q && ie_q;

endmodule

// File: rtl/dout_port_chk.sv
module dout_port_chk
  import dout_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_data,
  input logic              data_take,
  input logic              stat_take,
  input logic              done_take,
  input logic              sink_done,
  input logic              rdy_q,
  input logic              out_vld,
  input logic [CHAR_W-1:0] out_char,
  input logic              irq
);

  // R3: an accepted write yields a pulse and busy next cycle
  a_r3_accept_pulse: assert property (@(posedge clk) disable iff (rst)
    data_take |=> (out_vld && !rdy_q));

  // R3: the pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R4: a write while busy makes no pulse
  a_r4_busy_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !rdy_q) |=> !out_vld);

  // R4: the character changes only on an accepted write
  a_r4_code_hold: assert property (@(posedge clk) disable iff (rst)
    !data_take |=> $stable(out_char));

  // R5: done while busy makes the port ready
  a_r5_done_rise: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && sink_done) |=> rdy_q);

  // R5: busy persists without done
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && !sink_done) |=> !rdy_q);

  // R6: a status write leaves a ready port ready
  a_r6_ready_unwritten: assert property (@(posedge clk) disable iff (rst)
    (stat_take && rdy_q) |=> rdy_q);

  // R7: irq rises only after a done or a status write
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(done_take) || $past(stat_take)));

endmodule

bind dout_port dout_port_chk u_chk (
  .clk(clk), .rst(rst), .wr_data(wr_data), .data_take(data_take),
  .stat_take(stat_take), .done_take(done_take), .sink_done(sink_done),
  .rdy_q(rdy_q), .out_vld(out_vld), .out_char(out_char), .irq(irq)
);

// File: tb/dout_port_tb.sv
module dout_port_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        out_vld;
  logic [7:0]  out_char;
  logic        sink_done = 1'b0;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  int accepted = 0;
  bit finished = 0;
  bit prev_vld = 0;
  logic [7:0] exp_q[$];

  localparam logic [15:0] A_STAT = 16'hFE04;
  localparam logic [15:0] A_DATA = 16'hFE06;

  always #2.5 clk = ~clk;

  dout_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_vld(out_vld),
    .out_char(out_char), .sink_done(sink_done), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected status word, restated: ready in bit 15, enable in bit 14.
  function automatic logic [15:0] stat_exp(input bit r, input bit e);
    return (r ? 16'h8000 : 16'h0000) | (e ? 16'h4000 : 16'h0000);
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit exp_accept);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (exp_accept) begin
      exp_q.push_back(d[7:0]);
      accepted++;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic sink_ack();
    @(negedge clk);
    sink_done = 1'b1;
    @(negedge clk);
    sink_done = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each character pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_vld) begin
        pulses++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected pulse", {8'h0, out_char}, 16'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_char == e, "R3 char", {8'h0, out_char}, {8'h0, e});
        end
        if (prev_vld) check(1'b0, "R3 pulse longer than one cycle", 16'h1, 16'h0);
      end
      prev_vld = out_vld;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1, R2: reset state
    check(irq == 1'b0, "R1 irq", {15'h0, irq}, 16'h0);
    check(out_vld == 1'b0, "R1 vld", {15'h0, out_vld}, 16'h0);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R1 R2 status after reset", rd, stat_exp(1, 0));

    // R3: accepted write, upper bits of data discarded
    bus_write(A_DATA, 16'hAB41, 1);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(0, 0), "R3 ready cleared", rd, stat_exp(0, 0));

    // R4: write while busy ignored
    bus_write(A_DATA, 16'h0042, 0);
    @(negedge clk);
    check(out_vld == 1'b0, "R4 no pulse when busy", {15'h0, out_vld}, 16'h0);
    bus_read(A_DATA, rd);
    check(rd == 16'h0041, "R4 R8 data readback", rd, 16'h0041);

    // R5: done makes ready
    sink_ack();
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R5 ready after done", rd, stat_exp(1, 0));
    // R5: done while ready has no effect
    sink_ack();
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R5 done while ready", rd, stat_exp(1, 0));
    check(pulses == 1, "R5 no pulse from idle done", pulses[15:0], 16'd1);

    // R6, R7: enable interrupt
    bus_write(A_STAT, 16'h4000, 0);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 1), "R6 enable set", rd, stat_exp(1, 1));
    check(irq == 1'b1, "R7 irq ready and enabled", {15'h0, irq}, 16'h1);

    // R7: busy drops irq, done raises it
    bus_write(A_DATA, 16'h005A, 1);
    @(negedge clk);
    check(irq == 1'b0, "R7 irq low while busy", {15'h0, irq}, 16'h0);
    sink_ack();
    check(irq == 1'b1, "R7 irq after done", {15'h0, irq}, 16'h1);

    // R6: bit 15 written as 0 leaves ready; enable cleared
    bus_write(A_STAT, 16'h0000, 0);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R6 ready not writable", rd, stat_exp(1, 0));
    check(irq == 1'b0, "R7 irq off when disabled", {15'h0, irq}, 16'h0);
    // R6: bit 15 written as 1 while busy leaves busy
    bus_write(A_DATA, 16'h0031, 1);
    bus_write(A_STAT, 16'h8000, 0);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(0, 0), "R6 busy not overwritten", rd, stat_exp(0, 0));
    sink_ack();

    // R9: neighbouring addresses
    bus_write(16'hFE07, 16'h0077, 0);
    bus_write(16'hFE05, 16'h4000, 0);
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R9 no state change", rd, stat_exp(1, 0));
    bus_read(16'hFE05, rd);
    check(rd == 16'h0000, "R9 unmapped read", rd, 16'h0000);
    bus_read(A_DATA, rd);
    check(rd == 16'h0031, "R9 R8 data kept", rd, 16'h0031);

    // R4, R5: write in same cycle as done while busy
    bus_write(A_DATA, 16'h0061, 1);
    @(negedge clk);
    bus_addr = A_DATA; bus_wdata = 16'h0062; bus_wr = 1'b1; sink_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sink_done = 1'b0;
    bus_read(A_STAT, rd);
    check(rd == stat_exp(1, 0), "R5 ready with concurrent write", rd, stat_exp(1, 0));
    bus_read(A_DATA, rd);
    check(rd == 16'h0061, "R4 concurrent write dropped", rd, 16'h0061);

    // R3: a burst of characters
    for (int i = 0; i < 6; i++) begin
      bus_write(A_DATA, 16'h0100 + 16'(i * 7 + 3), 1);
      sink_ack();
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size() & 16'hFFFF, 16'h0);
    check(pulses == accepted, "R3 R4 pulse count", pulses[15:0], accepted[15:0]);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule